// File: doc/BRIEF.md
# Flash Command Register Erase Decoder

This block is the device side of a small byte-wide flash array model. Every write strobe on the bus carries a byte that is decoded as a command. The decoder steps through a mode machine for plain byte programming and for erasure. Erasure is armed in two steps: an erase-setup command followed at once by a confirming repeat. The erase then sweeps the array byte by byte under an internal timer until an erase-verify command stops it.

An erase-verify command carries the address of the byte to check. The following read returns that byte, whatever address the read itself presents, together with a flag that is set when every bit of the byte reads erased. The electrical margin check is reduced to this flag. A three-bit status output shows the current mode. Software reads every byte in turn with verify commands and repeats the erase until each one reports erased.

Top module: `flash_erase_ctrl`

## Requirements
- R1: After synchronous reset, `mode` is 0 (read), `rvalid` is 0 and every array byte holds FFh. Mode codes are: 0 read, 1 erase setup, 2 erasing, 3 verify, 4 program setup.
- R2: In read mode, a read strobe returns the byte at `addr` on `rdata` one cycle later, with `rvalid` high for that one cycle and `erased_ok` low.
- R3: A write of 40h enters program setup (mode 4). The next write stores its data byte at its address and returns to read mode.
- R4: A write of 20h from read, erasing or verify mode enters erase setup (mode 1).
- R5: From erase setup, a second write of 20h enters erasing (mode 2) and starts the sweep. Byte k becomes FFh at the clock edge TICK_DIV*(k+1) cycles after the edge that took the starting write. The sweep ends after the last byte.
- R6: From erase setup, a write of any value other than 20h returns to read mode and erases nothing.
- R7: A write of A0h enters verify mode (mode 3) and latches its address. If the sweep is running, it stops on that edge: bytes that are not yet erased keep their previous values.
- R8: In verify mode, a read returns the byte at the latched verify address, not at `addr`. `erased_ok` is high exactly when that byte is FFh. Outside verify mode, `erased_ok` stays low.
- R9: A write of any unrecognised value from read, erasing or verify mode returns to read mode and leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| we | input | 1 | Write strobe, one command or data byte per cycle |
| addr | input | ADDR_W | Address for writes and reads |
| wdata | input | 8 | Command or program data byte |
| re | input | 1 | Read strobe |
| rdata | output | 8 | Read data, registered |
| rvalid | output | 1 | Read data valid |
| erased_ok | output | 1 | Verify read found the byte fully erased |
| mode | output | 3 | Current mode code |

## Verification
The embedded properties assume that `we` and `re` are never high in the same cycle. A write and a read together would make the read observe pre-write data and the mode before decoding. The bench drives each access as a single-cycle strobe from a task, so the two never overlap. The properties also assume that `wdata` is meaningful only while `we` is high. The bench clears the write strobe between accesses and places each halting verify command at a chosen cycle count after the start of the erase, so that the partially erased state can be predicted exactly.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] CMD_ERASE   = 8'h20;
    localparam logic [BYTE_W-1:0] CMD_VERIFY  = 8'hA0;
    localparam logic [BYTE_W-1:0] CMD_PROGRAM = 8'h40;
    localparam logic [BYTE_W-1:0] ERASED_BYTE = 8'hFF;

    typedef enum logic [2:0] {
        MODE_READ    = 3'd0,
        MODE_ESETUP  = 3'd1,
        MODE_ERASING = 3'd2,
        MODE_VERIFY  = 3'd3,
        MODE_PSETUP  = 3'd4
    } mode_e;

    typedef struct packed {
        logic start_erase;
        logic halt_erase;
        logic prog_byte;
        logic latch_vaddr;
    } ctl_t;

    function automatic mode_e cmd_to_mode(input logic [BYTE_W-1:0] c);
        case (c)
            CMD_ERASE:   return MODE_ESETUP;
            CMD_VERIFY:  return MODE_VERIFY;
            CMD_PROGRAM: return MODE_PSETUP;
            default:     return MODE_READ;
        endcase
    endfunction

    function automatic logic is_erased(input logic [BYTE_W-1:0] b);
        return b == ERASED_BYTE;
    endfunction

endpackage

// File: rtl/fe_cmd_decode.sv
module fe_cmd_decode
    import flash_erase_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output mode_e             mode_q,
    output ctl_t              ctl,
    output logic [ADDR_W-1:0] vaddr_q
);

    mode_e mode_d;

    always_comb begin
        mode_d = mode_q;
        ctl    = '0;
        if (we) begin
            case (mode_q)
                MODE_ESETUP: begin
                    if (wdata == CMD_ERASE) begin
                        mode_d          = MODE_ERASING;
                        ctl.start_erase = 1'b1;
                    end else begin
                        mode_d = MODE_READ;
                    end
                end
                MODE_PSETUP: begin
                    ctl.prog_byte = 1'b1;
                    mode_d        = MODE_READ;
                end
                default: begin
                    ctl.halt_erase  = (mode_q == MODE_ERASING);
                    ctl.latch_vaddr = (wdata == CMD_VERIFY);
                    mode_d          = cmd_to_mode(wdata);
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MODE_READ;
            vaddr_q <= '0;
        end else begin
            mode_q <= mode_d;
            if (ctl.latch_vaddr) vaddr_q <= addr;
        end
    end

    // R5
    confirm_starts_erase_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_ESETUP && we && wdata == CMD_ERASE) |=> (mode_q == MODE_ERASING));

    // R6
    abort_setup_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_ESETUP && we && wdata != CMD_ERASE) |=> (mode_q == MODE_READ));

    // R7
    verify_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q != MODE_ESETUP && mode_q != MODE_PSETUP && we && wdata == CMD_VERIFY)
        |=> (mode_q == MODE_VERIFY && vaddr_q == $past(addr)));

    // R3
    program_returns_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_PSETUP && we) |=> (mode_q == MODE_READ));

endmodule

// File: rtl/fe_erase_timer.sv
module fe_erase_timer #(
    parameter int ADDR_W   = 4,
    parameter int TICK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              halt,
    output logic              erase_stb,
    output logic [ADDR_W-1:0] erase_idx,
    output logic              running
);

    localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(TICK_DIV - 1);
    localparam logic [ADDR_W-1:0] IDX_LAST = ADDR_W'((1 << ADDR_W) - 1);

    logic [CNT_W-1:0] cnt_q;

    assign erase_stb = running && !halt && (cnt_q == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            running   <= 1'b0;
            cnt_q     <= '0;
            erase_idx <= '0;
        end else if (start) begin
            running   <= 1'b1;
            cnt_q     <= '0;
            erase_idx <= '0;
        end else if (halt) begin
            running <= 1'b0;
        end else if (running) begin
            if (cnt_q == CNT_LAST) begin
                cnt_q     <= '0;
                erase_idx <= erase_idx + 1'b1;
                if (erase_idx == IDX_LAST) running <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R7
    halt_stops_chk: assert property (@(posedge clk) disable iff (rst)
        (halt && !start) |=> !running);

    // R5
    start_runs_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (running && erase_idx == '0));

endmodule

// File: rtl/fe_byte_array.sv
module fe_byte_array
    import flash_erase_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_en,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [BYTE_W-1:0] prog_data,
    input  logic              erase_en,
    input  logic [ADDR_W-1:0] erase_idx,
    input  logic              re,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              verify_rd,
    output logic [BYTE_W-1:0] rdata,
    output logic              rvalid,
    output logic              erased_ok
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[i] <= ERASED_BYTE;
            end else if (erase_en && erase_idx == ADDR_W'(i)) begin
                mem[i] <= ERASED_BYTE;
            end else if (prog_en && prog_addr == ADDR_W'(i)) begin
                mem[i] <= prog_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata     <= '0;
            rvalid    <= 1'b0;
            erased_ok <= 1'b0;
        end else begin
            rvalid <= re;
            if (re) begin
                rdata     <= mem[rd_addr];
                erased_ok <= verify_rd && is_erased(mem[rd_addr]);
            end else begin
                erased_ok <= 1'b0;
            end
        end
    end

    // R2
    read_valid_chk: assert property (@(posedge clk) disable iff (rst)
        re |=> rvalid);

    // R8
    verify_flag_chk: assert property (@(posedge clk) disable iff (rst)
        erased_ok |-> (rvalid && rdata == ERASED_BYTE));

endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
    import flash_erase_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int TICK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              re,
    output logic [7:0]        rdata,
    output logic              rvalid,
    output logic              erased_ok,
    output logic [2:0]        mode
);

    mode_e             mode_q;
    ctl_t              ctl;
    logic [ADDR_W-1:0] vaddr_q;
    logic              erase_stb;
    logic [ADDR_W-1:0] erase_idx;
    logic              erase_running;
    logic              in_verify;
    logic [ADDR_W-1:0] rd_sel;

    fe_cmd_decode #(.ADDR_W(ADDR_W)) u_decode (
        .clk     (clk),
        .rst     (rst),
        .we      (we),
        .addr    (addr),
        .wdata   (wdata),
        .mode_q  (mode_q),
        .ctl     (ctl),
        .vaddr_q (vaddr_q)
    );

    fe_erase_timer #(.ADDR_W(ADDR_W), .TICK_DIV(TICK_DIV)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .start     (ctl.start_erase),
        .halt      (ctl.halt_erase),
        .erase_stb (erase_stb),
        .erase_idx (erase_idx),
        .running   (erase_running)
    );

    assign in_verify = (mode_q == MODE_VERIFY);
    assign rd_sel    = in_verify ? vaddr_q : addr;

    fe_byte_array #(.ADDR_W(ADDR_W)) u_array (
        .clk       (clk),
        .rst       (rst),
        .prog_en   (ctl.prog_byte),
        .prog_addr (addr),
        .prog_data (wdata),
        .erase_en  (erase_stb),
        .erase_idx (erase_idx),
        .re        (re),
        .rd_addr   (rd_sel),
        .verify_rd (in_verify),
        .rdata     (rdata),
        .rvalid    (rvalid),
        .erased_ok (erased_ok)
    );

    assign mode = mode_q;

    // R5
    sweep_only_erasing_chk: assert property (@(posedge clk) disable iff (rst)
        erase_running |-> (mode_q == MODE_ERASING));

    // R9
    unknown_cmd_read_chk: assert property (@(posedge clk) disable iff (rst)
        (we && mode_q != MODE_ESETUP && mode_q != MODE_PSETUP &&
         wdata != CMD_ERASE && wdata != CMD_VERIFY && wdata != CMD_PROGRAM)
        |=> (mode_q == MODE_READ));

    // R8
    flag_needs_verify_chk: assert property (@(posedge clk) disable iff (rst)
        (re && mode_q != MODE_VERIFY) |=> !erased_ok);

endmodule

// File: tb/flash_erase_ctrl_tb.sv
module flash_erase_ctrl_tb;

    localparam int AW    = 4;
    localparam int TD    = 4;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic          we;
    logic [AW-1:0] addr;
    logic [7:0]    wdata;
    logic          re;
    logic [7:0]    rdata;
    logic          rvalid;
    logic          erased_ok;
    logic [2:0]    mode;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_mem [DEPTH];
    logic [8:0] q_exp [$];
    string      q_tag [$];

    always #4 clk = ~clk;

    flash_erase_ctrl #(.ADDR_W(AW), .TICK_DIV(TD)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .we        (we),
        .addr      (addr),
        .wdata     (wdata),
        .re        (re),
        .rdata     (rdata),
        .rvalid    (rvalid),
        .erased_ok (erased_ok),
        .mode      (mode)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d, input logic [AW-1:0] a);
        we = 1'b1; wdata = d; addr = a;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [7:0] d,
                      input logic ok, input string tag);
        q_exp.push_back({ok, d});
        q_tag.push_back(tag);
        re = 1'b1; addr = a;
        @(negedge clk);
        re = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops one expected item per valid read
    initial begin
        forever begin
            @(negedge clk);
            if (rvalid) begin
                if (q_exp.size() == 0) begin
                    check("unexpected read data", 1, 0);
                end else begin
                    logic [8:0] e;
                    string      t;
                    e = q_exp.pop_front();
                    t = q_tag.pop_front();
                    check(t, {erased_ok, rdata}, e);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; we = 1'b0; re = 1'b0; addr = '0; wdata = '0;
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'hFF;
        idle(3);
        rst = 1'b0;
        idle(1);
        // R1: reset state
        check("R1 mode", mode, 0);
        check("R1 rvalid", rvalid, 0);
        rd(4'd3, 8'hFF, 1'b0, "R1 array erased at reset");

        // R3: program every byte with a distinct value
        for (int i = 0; i < DEPTH; i++) begin
            wr(8'h40, '0);
            if (i == 0) check("R3 program setup mode", mode, 4);
            wr(8'(8'h11 * i + 8'h03), AW'(i));
            exp_mem[i] = 8'(8'h11 * i + 8'h03);
        end
        check("R3 back to read", mode, 0);
        // R2: normal reads at several addresses
        rd(4'd0, exp_mem[0], 1'b0, "R2 read byte 0");
        rd(4'd9, exp_mem[9], 1'b0, "R2 read byte 9");
        rd(4'd15, exp_mem[15], 1'b0, "R3 read byte 15");

        // R9: unrecognised command
        wr(8'h55, 4'd5);
        check("R9 unknown command mode", mode, 0);
        rd(4'd5, exp_mem[5], 1'b0, "R9 array unchanged");

        // R4 / R6: setup then abort
        wr(8'h20, '0);
        check("R4 erase setup mode", mode, 1);
        wr(8'h33, '0);
        check("R6 abort to read", mode, 0);
        idle(TD * 3);
        rd(4'd0, exp_mem[0], 1'b0, "R6 nothing erased");

        // R5 / R7: partial erase halted at edge h = 10 after start
        wr(8'h20, '0);
        wr(8'h20, '0);
        check("R5 erasing mode", mode, 2);
        idle(9);
        wr(8'hA0, 4'd7);
        for (int k = 0; k < DEPTH; k++)
            if (TD * (k + 1) < 10) exp_mem[k] = 8'hFF;
        check("R7 verify mode", mode, 3);
        rd(4'd9, exp_mem[7], 1'b0, "R8 verify uses latched address");
        wr(8'hA0, 4'd1);
        rd(4'd2, 8'hFF, 1'b1, "R7 byte 1 erased before halt");
        wr(8'hA0, 4'd2);
        rd(4'd1, exp_mem[2], 1'b0, "R7 byte 2 kept after halt");
        idle(TD * DEPTH);
        rd(4'd0, exp_mem[2], 1'b0, "R7 sweep stays stopped");

        // R9 from verify mode
        wr(8'h00, '0);
        check("R9 exit verify", mode, 0);
        rd(4'd0, 8'hFF, 1'b0, "R8 no flag outside verify");
        rd(4'd3, exp_mem[3], 1'b0, "R2 read byte 3");

        // R5: full erase
        wr(8'h20, '0);
        wr(8'h20, '0);
        idle(TD * DEPTH + 6);
        check("R5 still erasing", mode, 2);
        for (int k = 0; k < DEPTH; k++) exp_mem[k] = 8'hFF;
        for (int k = 0; k < DEPTH; k++) begin
            wr(8'hA0, AW'(k));
            rd(AW'(DEPTH - 1 - k), 8'hFF, 1'b1, "R5 full erase verify");
        end

        // R8: programmed zero fails verify
        wr(8'h40, '0);
        wr(8'h00, 4'd4);
        wr(8'hA0, 4'd4);
        rd(4'd5, 8'h00, 1'b0, "R8 zero byte not erased");

        idle(4);
        check("R2 scoreboard drained", q_exp.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule